// File: doc/BRIEF.md
# Successive-Approximation Sequencer with Selectable Output Coding

This block runs an 8-bit successive-approximation conversion against an external DAC and a single-bit comparator. A start request arms a conversion. The sequencer then tests the bits one at a time, starting at the most significant bit. For each bit it drives a trial code onto `dac_code` and holds that code for a fixed number of cycles so the analog path can settle. In the last cycle of the step it samples `cmp_keep`. If the comparator reports that the trial code does not exceed the input, the bit stays set. Otherwise the bit is cleared.

Two mode pins are captured when a conversion is accepted. `mode_bipolar` marks the input range as offset by half scale. `mode_twos` chooses between plain binary and two's complement. The offset is applied to the digital code only, so the raw register is always an unsigned code. At the end of a conversion the coded result is registered and held until the next conversion ends. A single-cycle `eoc` pulse marks that moment. All pins are plain levels or pulses. The result carries no back-pressure: it is a held register that the consumer reads whenever it likes after `eoc`.

The step length is derived from a total conversion budget and the clock period. The defaults are 10 µs at 5 ns, which gives 250 cycles per bit.

Top module: `sar_coder`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `eoc`, `cmp_strobe`, `result`, `result_neg` and `dac_code` are all zero.
- R2: A high `start` sampled while `busy` is low makes `busy` high in the next cycle. The first trial code on `dac_code` is then 8'h80.
- R3: Bits are tested strictly from bit 7 down to bit 0. Each step lasts STEP_CYC cycles. `cmp_strobe` is high in the last cycle of each step. At that strobe, `dac_code` equals the bits already decided, plus the current trial bit, with all lower bits zero.
- R4: `busy` stays high for exactly 8*STEP_CYC cycles. `eoc` is then high for one cycle while `busy` is low.
- R5: `start` raised while `busy` is high has no effect. The running conversion keeps its length, and no new conversion follows it.
- R6: `dac_code` is zero whenever `busy` is low.
- R7: A bit is kept exactly when `cmp_keep` is 1 at its strobe. With an ideal comparator (`cmp_keep` = trial code ≤ input code), the raw code equals the input code.
- R8: With `mode_twos`=0, `result` equals the raw code. This is straight binary in unipolar mode and offset binary in bipolar mode, where a zero input is 8'h80. With `mode_twos`=1, `result` is the raw code with bit 7 inverted. In bipolar mode this is two's complement: zero gives 8'h00, −1 gives 8'hFF and −128 gives 8'h80.
- R9: `result_neg` is 1 only in bipolar mode when raw bit 7 is 0, meaning the input is below mid-scale. In unipolar mode it is 0.
- R10: The mode pins are captured when `start` is accepted. Changing them during a conversion does not alter that conversion's result.
- R11: `result` and `result_neg` change only in a cycle where `eoc` is high, and they hold their value between conversions.
- R12: If `start` is still high in the `eoc` cycle, the next conversion begins at once: `busy` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, level-sampled while idle |
| mode_bipolar | input | 1 | Half-scale offset range, captured at start |
| mode_twos | input | 1 | Two's-complement output coding, captured at start |
| cmp_keep | input | 1 | Comparator: 1 when trial code ≤ input |
| dac_code | output | 8 | Trial code to the DAC, zero when idle |
| cmp_strobe | output | 1 | Comparator sample point, last cycle of each step |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 8 | Coded result of the last conversion |
| result_neg | output | 1 | Bipolar result below mid-scale |

## Verification
The assertions assume that `cmp_keep` is meaningful only at strobe cycles. They also assume that `start` may be raised at any time, including during a conversion. They place no other constraint on the inputs.

The bench models the comparator as an ideal digital compare of `dac_code` against an input code. That input code is held constant for the whole of each conversion, which keeps the comparator answers consistent from one step to the next.

Mode pins and `start` are disturbed only in the middle of a conversion, where the requirements say they must be ignored.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  // Mode captured when a conversion is accepted
  typedef struct packed {
    logic bipolar;
    logic twos;
  } sar_mode_t;
endpackage

// File: rtl/sar_step_timer.sv
`timescale 1ns/1ps
module sar_step_timer #(
  parameter int STEP_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic step_last
);
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

  logic [CW-1:0] cnt;

  assign step_last = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || step_last) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_bit_ctrl.sv
`timescale 1ns/1ps
module sar_bit_ctrl #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             step_last,
  input  logic             keep,
  output logic             busy,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] raw_next,
  output logic             done
);
  logic [NBITS-1:0] ptr;   // one-hot bit under test
  logic [NBITS-1:0] work;  // bits decided so far

  genvar i;
  generate
    for (i = 0; i < NBITS; i++) begin : g_bit
      assign raw_next[i] = work[i] | (ptr[i] & keep);
      assign trial[i]    = busy & (work[i] | ptr[i]);
    end
  endgenerate

  assign done = busy && step_last && ptr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
      work <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      ptr  <= {1'b1, {(NBITS-1){1'b0}}};
      work <= '0;
    end else if (busy && step_last) begin
      work <= raw_next;
      ptr  <= ptr >> 1;
      if (ptr[0]) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_out_coder.sv
`timescale 1ns/1ps
module sar_out_coder
  import sar_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NBITS-1:0] raw,
  input  sar_mode_t        mode,
  output logic [NBITS-1:0] result,
  output logic             neg
);
  localparam int MSB = NBITS - 1;

  logic [NBITS-1:0] coded;

  genvar i;
  generate
    for (i = 0; i < NBITS; i++) begin : g_code
      if (i == MSB) begin : g_top
        assign coded[i] = raw[i] ^ mode.twos;
      end else begin : g_low
        assign coded[i] = raw[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      neg    <= 1'b0;
    end else if (load) begin
      result <= coded;
      neg    <= mode.bipolar & ~raw[MSB];
    end
  end
endmodule

// File: rtl/sar_coder.sv
`timescale 1ns/1ps
module sar_coder
  import sar_pkg::*;
#(
  parameter int NBITS   = 8,
  parameter int CONV_NS = 10000,
  parameter int CLK_NS  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_bipolar,
  input  logic             mode_twos,
  input  logic             cmp_keep,
  output logic [NBITS-1:0] dac_code,
  output logic             cmp_strobe,
  output logic             busy,
  output logic             eoc,
  output logic [NBITS-1:0] result,
  output logic             result_neg
);
  localparam int STEP_RAW = CONV_NS / (CLK_NS * NBITS);
  localparam int STEP_CYC = (STEP_RAW < 1) ? 1 : STEP_RAW;

  logic             launch, step_last, done;
  logic [NBITS-1:0] raw_next;
  sar_mode_t        mode_q;

  assign launch     = start & ~busy;
  assign cmp_strobe = step_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      eoc    <= 1'b0;
    end else begin
      if (launch) mode_q <= '{bipolar: mode_bipolar, twos: mode_twos};
      eoc <= done;
    end
  end

  sar_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .step_last(step_last)
  );

  sar_bit_ctrl #(.NBITS(NBITS)) u_bits (
    .clk(clk), .rst_n(rst_n), .launch(launch), .step_last(step_last),
    .keep(cmp_keep), .busy(busy), .trial(dac_code),
    .raw_next(raw_next), .done(done)
  );

  sar_out_coder #(.NBITS(NBITS)) u_coder (
    .clk(clk), .rst_n(rst_n), .load(done), .raw(raw_next),
    .mode(mode_q), .result(result), .neg(result_neg)
  );
endmodule

// File: rtl/sar_coder_chk.sv
`timescale 1ns/1ps
module sar_coder_chk #(
  parameter int NBITS    = 8,
  parameter int STEP_CYC = 250
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             eoc,
  input logic             cmp_strobe,
  input logic [NBITS-1:0] dac_code,
  input logic [NBITS-1:0] result,
  input logic             result_neg
);
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= 0;
    else        busy_run <= busy ? busy_run + 1 : 0;
  end

  p_idle_dac_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dac_code == '0);

  p_first_trial_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> dac_code == {1'b1, {(NBITS-1){1'b0}}});

  p_start_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmp_strobe) |=> busy);

  p_strobe_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> busy);

  p_eoc_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  p_eoc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> !busy);

  p_eoc_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> busy_run == NBITS * STEP_CYC);

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> ($stable(result) && $stable(result_neg)));
endmodule

bind sar_coder sar_coder_chk #(.NBITS(NBITS), .STEP_CYC(STEP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .eoc(eoc),
  .cmp_strobe(cmp_strobe), .dac_code(dac_code), .result(result),
  .result_neg(result_neg)
);

// File: tb/sim_sar_coder.sv
`timescale 1ns/1ps
module sim_sar_coder;
  localparam int NB   = 8;
  localparam int STEP = 10000 / (5 * NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, bip = 1'b0, twos = 1'b0;
  logic [NB-1:0] vin = '0;
  logic          cmp_keep;
  logic [NB-1:0] dac_code, result;
  logic          cmp_strobe, busy, eoc, result_neg;

  int tests = 0, fails = 0;
  int strobe_idx = 0;
  logic [NB:0] expq[$];

  always #2.5 clk = ~clk;

  // Ideal comparator model
  assign cmp_keep = (dac_code <= vin);

  sar_coder #(.NBITS(NB), .CONV_NS(10000), .CLK_NS(5)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_bipolar(bip),
    .mode_twos(twos), .cmp_keep(cmp_keep), .dac_code(dac_code),
    .cmp_strobe(cmp_strobe), .busy(busy), .eoc(eoc), .result(result),
    .result_neg(result_neg)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NB:0] expect_of(logic [NB-1:0] raw, logic b, logic t);
    return {b & ~raw[NB-1], raw ^ {t, {(NB-1){1'b0}}}};
  endfunction

  // Monitor: scoreboard pop on end of conversion
  always @(negedge clk) begin
    if (rst_n && eoc) begin
      if (expq.size() == 0) chk(1'b0, "R8 unexpected eoc", int'(result), 0);
      else begin
        logic [NB:0] e;
        e = expq.pop_front();
        chk({result_neg, result} == e, "R7/R8/R9 result", int'({result_neg, result}), int'(e));
      end
    end
  end

  // Monitor: trial code at every strobe (MSB first)
  always @(negedge clk) begin
    if (rst_n && cmp_strobe) begin
      int b, ex;
      b  = NB - 1 - (strobe_idx % NB);
      ex = (int'(vin) & ((32'hFF << (b + 1)) & 32'hFF)) | (1 << b);
      chk(int'(dac_code) == ex, "R3 trial code", int'(dac_code), ex);
      strobe_idx++;
    end
  end

  task automatic do_conv(input logic [NB-1:0] raw, input logic b, input logic t,
                         input bit disturb);
    int n;
    @(negedge clk);
    vin = raw; bip = b; twos = t; start = 1'b1;
    strobe_idx = 0;
    expq.push_back(expect_of(raw, b, t));
    @(negedge clk);
    start = 1'b0;
    chk(busy && dac_code == 8'h80, "R2 launch", int'({busy, dac_code}), 'h180);
    n = 1;
    while (1) begin
      @(negedge clk);
      if (!busy) break;
      n++;
      if (disturb && n == 600) begin   // R5 and R10 disturbance
        start = 1'b1; bip = ~b; twos = ~t;
      end
      if (disturb && n == 602) start = 1'b0;
    end
    chk(n == NB * STEP, "R4 busy length", n, NB * STEP);
    chk(eoc == 1'b1, "R4 eoc after busy", int'(eoc), 1);
    @(negedge clk);
    chk(!busy && !eoc, "R5 no extra conversion / R4 eoc one cycle", int'({busy, eoc}), 0);
    chk(dac_code == '0, "R6 idle dac zero", int'(dac_code), 0);
  endtask

  initial begin
    logic [NB-1:0] held;
    repeat (4) @(negedge clk);
    chk({busy, eoc, cmp_strobe, result_neg, result, dac_code} == '0,
        "R1 reset state", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, eoc, result, dac_code} == '0, "R1 after reset", int'(result), 0);

    do_conv(8'hA5, 0, 0, 0);   // straight binary
    do_conv(8'h00, 0, 0, 0);
    do_conv(8'hFF, 0, 0, 0);
    do_conv(8'h37, 0, 1, 0);   // unipolar, MSB inverted -> B7
    do_conv(8'h80, 1, 0, 0);   // bipolar zero offset binary -> 80
    do_conv(8'h80, 1, 1, 0);   // bipolar zero two's -> 00
    do_conv(8'h7F, 1, 1, 0);   // -1 -> FF, negative
    do_conv(8'h00, 1, 1, 0);   // -128 -> 80, negative
    do_conv(8'hFF, 1, 0, 0);   // +127 offset binary -> FF
    do_conv(8'h40, 1, 1, 1);   // R5/R10: disturbed mid-conversion -> C0, neg

    // R11: result held between conversions
    held = result;
    vin = 8'h11; bip = 1'b0; twos = 1'b0;
    repeat (50) @(negedge clk);
    chk(result == held && result_neg == 1'b1 && !eoc, "R11 result held",
        int'(result), int'(held));

    // R12: start held, back-to-back conversions
    @(negedge clk);
    vin = 8'h5A; bip = 1'b1; twos = 1'b1; start = 1'b1;
    strobe_idx = 0;
    for (int e = 0; e < 3; e++) expq.push_back(expect_of(8'h5A, 1, 1));
    for (int e = 0; e < 3; e++) begin
      do @(negedge clk); while (!eoc);
      if (e == 2) start = 1'b0;
      else begin
        @(negedge clk);
        chk(busy == 1'b1, "R12 immediate restart", int'(busy), 1);
      end
    end
    repeat (3) @(negedge clk);
    chk(!busy, "R12 stop after release", int'(busy), 0);
    chk(expq.size() == 0, "R4 all conversions ended", expq.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule